// File: doc/BRIEF.md
# Packet Receive Deframer with De-whitening

This block sits behind a demodulator and turns a serial bit stream into packet bytes for a receive FIFO. Each incoming bit is marked by a one-cycle valid strobe. While idle, the block looks for a programmable sync pattern in the most recent bits. The pattern is either a 16-bit word or that word sent twice. When the pattern is found, the bit that follows starts the first byte. From then on, each group of eight bits forms one byte, most significant bit first.

Each byte can be XORed with a PN9 mask to undo whitening. The first byte can be compared against a device address. A CRC-16 is accumulated over all received bytes. Payload bytes go out on a one-byte FIFO write port. If status append is enabled, two more bytes follow the payload: a signal-strength byte, then a byte that carries the CRC verdict and a link-quality value. Once the frame is finished, the block goes back to searching.

All configuration inputs are treated as static while a frame is in progress. The signal-strength and link-quality inputs are sampled in the cycle in which their status byte is formed.

Top module: `pkt_deframer`

## Requirements
- R1: The sync search runs on every valid bit while the block is idle. A hit is accepted on the valid bit that completes the pattern, and only after at least 16 bits (32 in double mode) have arrived since the search began. The next valid bit is the most significant bit of the first byte.
- R2: With `sync_exact_i`=1, all 16 bits must equal `sync_word_i`. With `sync_exact_i`=0, at most one of the 16 bits may differ.
- R3: With `sync_double_i`=1, the last 32 bits must be `sync_word_i` followed by `sync_word_i` again. Each half is judged against the R2 threshold on its own. A single 16-bit word is not enough.
- R4: With `pq_gate_en_i`=1, a sync hit counts only if `pq_ok_i`=1 on the completing bit. With `pq_gate_en_i`=0, `pq_ok_i` is ignored.
- R5: With `white_en_i`=1, every byte after the sync pattern is XORed with a PN9 mask. The 9-bit register is loaded with 0x1FF at the sync hit. Each byte's mask is bits 7:0 of the register. After each byte, the register takes 8 steps, and each step shifts right with a new bit 8 equal to bit0 XOR bit5. Sync and preamble are never de-whitened.
- R6: With `crc_en_i`=1, two CRC bytes follow the payload, high byte first. Both are de-whitened, and neither is written to the FIFO. The CRC is CRC-16, polynomial 0x8005, seed 0xFFFF, MSB first, with no final XOR, computed over the de-whitened payload. CRC_OK is 1 on a match or when `crc_en_i`=0, and 0 on a mismatch.
- R7: With `status_en_i`=1, the two writes in the cycles right after the last payload write are `rssi_i` and then {CRC_OK in bit 7, `lqi_i` in bits 6:0}.
- R8: With `addr_chk_en_i`=1, a first byte that differs from `dev_addr_i` drops the frame. Nothing is written, and the search resumes. A matching address byte is written as payload.
- R9: The frame carries exactly `pkt_len_i` payload bytes (at least 1). Each byte is written on `fifo_wr_o` for one cycle, one clock after its last bit. After the last write of the frame, the block searches again. With `status_en_i`=0, no status bytes are written.
- R10: During and after reset, `fifo_wr_o`=0 and `fifo_data_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Demodulated data bit |
| bit_valid_i | input | 1 | One-cycle strobe marking a valid bit |
| sync_word_i | input | SYNC_W | Sync pattern |
| sync_double_i | input | 1 | Expect the sync word twice |
| sync_exact_i | input | 1 | 1: exact match, 0: one mismatch allowed |
| pq_gate_en_i | input | 1 | Qualify sync hits by preamble quality |
| pq_ok_i | input | 1 | Preamble quality good |
| white_en_i | input | 1 | Enable PN9 de-whitening |
| crc_en_i | input | 1 | CRC bytes present and checked |
| status_en_i | input | 1 | Append two status bytes |
| addr_chk_en_i | input | 1 | Enable first-byte address filter |
| dev_addr_i | input | 8 | Device address |
| pkt_len_i | input | LEN_W | Payload length in bytes |
| rssi_i | input | 8 | Signal-strength value for status |
| lqi_i | input | 7 | Link-quality value for status |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | 8 | FIFO write data |

## Verification
Two decisions land on the same clock edge as the last valid bit of the frame. The final CRC byte is folded into the checksum on that edge, and the frame end is decided on that edge too. The status byte must see the residue that includes that final byte. Frames are sent with a correct CRC and with a single bit flipped in the very last transmitted bit, and bit 7 of the second status byte must follow. A similar collision occurs on the first byte: the address decision and the first FIFO write fall on the same edge. A mismatching address must produce no write at all, and the next frame that follows at once must still be found.

// File: rtl/deframer_pkg.sv
`timescale 1ns/1ps
package deframer_pkg;
  localparam int BYTE_W = 8;
  localparam int PN_W   = 9;
  localparam int PN_TAP = 5;
  localparam int CRC_W  = 16;
  localparam int LQI_W  = 7;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_DATA   = 2'd1,
    ST_RSSI   = 2'd2,
    ST_STAT   = 2'd3
  } dfr_state_e;
endpackage

// File: rtl/sync_det.sv
`timescale 1ns/1ps
module sync_det #(
  parameter int SYNC_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic              search_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic              double_i,
  input  logic              exact_i,
  input  logic              pq_gate_i,
  input  logic              pq_ok_i,
  output logic              hit_o
);
  localparam int SH_W  = 2 * SYNC_W;
  localparam int CNT_W = $clog2(SH_W + 2);
  localparam int ERR_W = $clog2(SYNC_W + 1);

  logic [SH_W-2:0]  sh_q;
  logic [SH_W-1:0]  sh_n;
  logic [CNT_W-1:0] cnt_q, cnt_inc, need;
  logic [ERR_W-1:0] err_lo, err_hi, lim;
  logic             ok_lo, ok_hi, filled;

  function automatic logic [ERR_W-1:0] ones(input logic [SYNC_W-1:0] v);
    logic [ERR_W-1:0] n;
    n = '0;
    for (int i = 0; i < SYNC_W; i++) n = n + ERR_W'(v[i]);
    return n;
  endfunction

  assign sh_n    = {sh_q, bit_i};
  assign err_lo  = ones(sh_n[SYNC_W-1:0] ^ sync_word_i);
  assign err_hi  = ones(sh_n[SH_W-1:SYNC_W] ^ sync_word_i);
  assign lim     = exact_i ? '0 : ERR_W'(1);
  assign ok_lo   = err_lo <= lim;
  assign ok_hi   = err_hi <= lim;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign need    = double_i ? CNT_W'(SH_W) : CNT_W'(SYNC_W);
  assign filled  = cnt_inc >= need;

  assign hit_o = search_i && bit_valid_i && filled && ok_lo &&
                 (!double_i || ok_hi) && (!pq_gate_i || pq_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (!search_i) begin
      cnt_q <= '0;
    end else if (bit_valid_i) begin
      sh_q <= sh_n[SH_W-2:0];
      if (cnt_q != CNT_W'(SH_W)) cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/pn9_gen.sv
`timescale 1ns/1ps
module pn9_gen #(
  parameter int PN_W  = 9,
  parameter int TAP   = 5,
  parameter int OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  output logic [OUT_W-1:0] mask_o
);
  logic [PN_W-1:0] s_q, s_nxt;

  always_comb begin
    s_nxt = s_q;
    for (int i = 0; i < OUT_W; i++) s_nxt = {s_nxt[0] ^ s_nxt[TAP], s_nxt[PN_W-1:1]};
  end

  assign mask_o = s_q[OUT_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     s_q <= '1;
    else if (load_i) s_q <= '1;
    else if (adv_i)  s_q <= s_nxt;
  end
endmodule

// File: rtl/crc16_acc.sv
`timescale 1ns/1ps
module crc16_acc #(
  parameter int               CRC_W = 16,
  parameter int               IN_W  = 8,
  parameter logic [CRC_W-1:0] POLY  = 16'h8005,
  parameter logic [CRC_W-1:0] SEED  = 16'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = crc_q;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (crc_nxt[CRC_W-1] ^ data_i[i]) crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^ POLY;
      else                               crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0};
    end
  end

  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= SEED;
    else if (init_i) crc_q <= SEED;
    else if (en_i)   crc_q <= crc_nxt;
  end
endmodule

// File: rtl/pkt_deframer.sv
`timescale 1ns/1ps
module pkt_deframer
  import deframer_pkg::*;
#(
  parameter int SYNC_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  input  logic [SYNC_W-1:0] sync_word_i,
  input  logic              sync_double_i,
  input  logic              sync_exact_i,
  input  logic              pq_gate_en_i,
  input  logic              pq_ok_i,
  input  logic              white_en_i,
  input  logic              crc_en_i,
  input  logic              status_en_i,
  input  logic              addr_chk_en_i,
  input  logic [7:0]        dev_addr_i,
  input  logic [LEN_W-1:0]  pkt_len_i,
  input  logic [7:0]        rssi_i,
  input  logic [6:0]        lqi_i,
  output logic              fifo_wr_o,
  output logic [7:0]        fifo_data_o
);
  localparam int IDX_W = LEN_W + 1;
  localparam int BC_W  = $clog2(BYTE_W);

  dfr_state_e        state_q;
  logic [BC_W-1:0]   bit_cnt_q;
  logic [BYTE_W-2:0] byte_sh_q;
  logic [IDX_W-1:0]  byte_idx_q, total;
  logic              wr_q;
  logic [BYTE_W-1:0] data_q;

  logic              search, sync_hit, byte_done, last_byte, in_payload, addr_bad, crc_ok;
  logic [BYTE_W-1:0] byte_raw, byte_clr, pn_mask;
  logic [CRC_W-1:0]  crc_val;

  assign search = (state_q == ST_SEARCH);

  sync_det #(.SYNC_W(SYNC_W)) i_sync_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .search_i    (search),
    .sync_word_i (sync_word_i),
    .double_i    (sync_double_i),
    .exact_i     (sync_exact_i),
    .pq_gate_i   (pq_gate_en_i),
    .pq_ok_i     (pq_ok_i),
    .hit_o       (sync_hit)
  );

  assign byte_done = (state_q == ST_DATA) && bit_valid_i && (bit_cnt_q == BC_W'(BYTE_W - 1));
  assign byte_raw  = {byte_sh_q, bit_i};

  pn9_gen #(.PN_W(PN_W), .TAP(PN_TAP), .OUT_W(BYTE_W)) i_pn9_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (sync_hit),
    .adv_i  (byte_done),
    .mask_o (pn_mask)
  );

  assign byte_clr = white_en_i ? (byte_raw ^ pn_mask) : byte_raw;

  crc16_acc #(.CRC_W(CRC_W), .IN_W(BYTE_W)) i_crc16_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (sync_hit),
    .en_i   (byte_done),
    .data_i (byte_clr),
    .crc_o  (crc_val)
  );

  // residue over payload plus received CRC is zero on a match
  assign crc_ok     = !crc_en_i || (crc_val == '0);
  assign total      = IDX_W'(pkt_len_i) + (crc_en_i ? IDX_W'(2) : IDX_W'(0));
  assign last_byte  = (byte_idx_q == total - IDX_W'(1));
  assign in_payload = (byte_idx_q < IDX_W'(pkt_len_i));
  assign addr_bad   = addr_chk_en_i && (byte_idx_q == '0) && (byte_clr != dev_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_SEARCH;
      bit_cnt_q  <= '0;
      byte_sh_q  <= '0;
      byte_idx_q <= '0;
      wr_q       <= 1'b0;
      data_q     <= '0;
    end else begin
      wr_q <= 1'b0;
      unique case (state_q)
        ST_SEARCH: begin
          if (sync_hit) begin
            state_q    <= ST_DATA;
            bit_cnt_q  <= '0;
            byte_idx_q <= '0;
          end
        end
        ST_DATA: begin
          if (bit_valid_i) begin
            byte_sh_q <= byte_raw[BYTE_W-2:0];
            bit_cnt_q <= bit_cnt_q + BC_W'(1);
            if (byte_done) begin
              if (addr_bad) begin
                state_q <= ST_SEARCH;
              end else begin
                if (in_payload) begin
                  wr_q   <= 1'b1;
                  data_q <= byte_clr;
                end
                byte_idx_q <= byte_idx_q + IDX_W'(1);
                if (last_byte) state_q <= status_en_i ? ST_RSSI : ST_SEARCH;
              end
            end
          end
        end
        ST_RSSI: begin
          wr_q    <= 1'b1;
          data_q  <= rssi_i;
          state_q <= ST_STAT;
        end
        ST_STAT: begin
          wr_q    <= 1'b1;
          data_q  <= {crc_ok, lqi_i};
          state_q <= ST_SEARCH;
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  assign fifo_wr_o   = wr_q;
  assign fifo_data_o = data_q;
endmodule

// File: rtl/deframer_chk.sv
`timescale 1ns/1ps
module deframer_chk
  import deframer_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input dfr_state_e state_q,
  input logic       sync_hit,
  input logic       byte_done,
  input logic       addr_bad,
  input logic       crc_en_i,
  input logic [7:0] rssi_i,
  input logic [6:0] lqi_i,
  input logic       fifo_wr_o,
  input logic [7:0] fifo_data_o
);
  assert_search_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH && !sync_hit) |=> (state_q == ST_SEARCH));

  assert_rssi_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RSSI) |=> (fifo_wr_o && fifo_data_o == $past(rssi_i)));

  assert_lqi_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAT) |=> (fifo_wr_o && fifo_data_o[6:0] == $past(lqi_i)));

  assert_crc_off_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STAT && !crc_en_i) |=> fifo_data_o[7]);

  assert_addr_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && addr_bad) |=> (!fifo_wr_o && state_q == ST_SEARCH));

  assert_wr_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_wr_o |-> ($past(state_q) != ST_SEARCH));
endmodule

bind pkt_deframer deframer_chk i_deframer_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_q     (state_q),
  .sync_hit    (sync_hit),
  .byte_done   (byte_done),
  .addr_bad    (addr_bad),
  .crc_en_i    (crc_en_i),
  .rssi_i      (rssi_i),
  .lqi_i       (lqi_i),
  .fifo_wr_o   (fifo_wr_o),
  .fifo_data_o (fifo_data_o)
);

// File: tb/test_pkt_deframer.sv
`timescale 1ns/1ps
module test_pkt_deframer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_i = 1'b0, bit_valid_i = 1'b0;
  logic [15:0] sync_word_i = 16'hD391;
  logic        sync_double_i = 0, sync_exact_i = 1, pq_gate_en_i = 0, pq_ok_i = 0;
  logic        white_en_i = 0, crc_en_i = 0, status_en_i = 0, addr_chk_en_i = 0;
  logic [7:0]  dev_addr_i = 8'h5A;
  logic [7:0]  pkt_len_i = 8'd3;
  logic [7:0]  rssi_i = 8'hC4;
  logic [6:0]  lqi_i = 7'h2B;
  logic        fifo_wr_o;
  logic [7:0]  fifo_data_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] cap[$];

  always #4 clk = ~clk;

  pkt_deframer i_pkt_deframer (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_valid_i(bit_valid_i),
    .sync_word_i(sync_word_i), .sync_double_i(sync_double_i), .sync_exact_i(sync_exact_i),
    .pq_gate_en_i(pq_gate_en_i), .pq_ok_i(pq_ok_i), .white_en_i(white_en_i),
    .crc_en_i(crc_en_i), .status_en_i(status_en_i), .addr_chk_en_i(addr_chk_en_i),
    .dev_addr_i(dev_addr_i), .pkt_len_i(pkt_len_i), .rssi_i(rssi_i), .lqi_i(lqi_i),
    .fifo_wr_o(fifo_wr_o), .fifo_data_o(fifo_data_o)
  );

  always @(negedge clk) if (rst_ni && fifo_wr_o) cap.push_back(fifo_data_o);

  function automatic logic [7:0] pn_mask(int k);
    logic [8:0] s = 9'h1FF;
    for (int j = 0; j < 8 * k; j++) s = {s[0] ^ s[5], s[8:1]};
    return s[7:0];
  endfunction

  function automatic logic [15:0] crc16(logic [7:0] d[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (d[n])
      for (int i = 7; i >= 0; i--) begin
        logic fb = c[15] ^ d[n][i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
      end
    return c;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_bytes(string tag, logic [7:0] exp[$]);
    check({tag, " count"}, cap.size(), exp.size());
    foreach (exp[i]) if (i < cap.size()) check({tag, " byte"}, cap[i], exp[i]);
    cap.delete();
  endtask

  task automatic send_bit(logic b);
    @(negedge clk);
    bit_i = b;
    bit_valid_i = 1'b1;
    @(negedge clk);
    bit_valid_i = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  // nsync sync words; sync_flip toggles bit 0 of the last one; tail_flip toggles last body bit
  task automatic send_frame(logic [7:0] pl[$], int nsync, bit sync_flip, bit tail_flip);
    logic [7:0]  body[$];
    logic [15:0] c;
    body = pl;
    if (crc_en_i) begin
      c = crc16(pl);
      body.push_back(c[15:8]);
      body.push_back(c[7:0]);
    end
    send_byte(8'hAA);
    send_byte(8'hAA);
    for (int s = 0; s < nsync; s++) begin
      send_byte(sync_word_i[15:8]);
      send_byte((s == nsync - 1 && sync_flip) ? (sync_word_i[7:0] ^ 8'h01) : sync_word_i[7:0]);
    end
    foreach (body[k]) begin
      logic [7:0] b = white_en_i ? (body[k] ^ pn_mask(k)) : body[k];
      if (tail_flip && k == body.size() - 1) b = b ^ 8'h01;
      send_byte(b);
    end
    send_byte(8'h00);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset wr", fifo_wr_o, 0);
    check("R10 reset data", fifo_data_o, 0);
  endtask

  task automatic t_basic();
    logic [7:0] pl[$] = '{8'h11, 8'hE7, 8'h3C};
    cap.delete();
    send_frame(pl, 1, 0, 0);
    check_bytes("R1 R9 plain frame", pl);
    send_frame('{8'h81, 8'h42, 8'h00}, 1, 0, 0);
    check_bytes("R9 back-to-back frame", '{8'h81, 8'h42, 8'h00});
  endtask

  task automatic t_white_crc_status();
    logic [7:0] pl[$] = '{8'h01, 8'h02, 8'hF0, 8'h99};
    logic [7:0] ex[$];
    white_en_i = 1; crc_en_i = 1; status_en_i = 1; pkt_len_i = 4;
    ex = pl; ex.push_back(rssi_i); ex.push_back({1'b1, lqi_i});
    send_frame(pl, 1, 0, 0);
    check_bytes("R5 R6 R7 whitened frame good crc", ex);
    ex = pl; ex.push_back(rssi_i); ex.push_back({1'b0, lqi_i});
    send_frame(pl, 1, 0, 1);
    check_bytes("R6 crc error in last bit", ex);
    crc_en_i = 0; lqi_i = 7'h05; rssi_i = 8'h17;
    ex = pl; ex.push_back(8'h17); ex.push_back({1'b1, 7'h05});
    send_frame(pl, 1, 0, 0);
    check_bytes("R6 R7 crc disabled reads ok", ex);
    white_en_i = 0; status_en_i = 0; pkt_len_i = 3;
  endtask

  task automatic t_threshold();
    logic [7:0] pl[$] = '{8'h55, 8'h0F, 8'hC3};
    sync_exact_i = 1;
    send_frame(pl, 1, 1, 0);
    check_bytes("R2 exact rejects one error", '{});
    sync_exact_i = 0;
    send_frame(pl, 1, 1, 0);
    check_bytes("R2 relaxed accepts one error", pl);
    sync_exact_i = 1;
  endtask

  task automatic t_double();
    logic [7:0] pl[$] = '{8'h12, 8'h34, 8'h56};
    sync_double_i = 1;
    send_frame(pl, 1, 0, 0);
    check_bytes("R3 single word not enough", '{});
    send_frame(pl, 2, 0, 0);
    check_bytes("R3 double word accepted", pl);
    sync_double_i = 0;
  endtask

  task automatic t_pq_gate();
    logic [7:0] pl[$] = '{8'h6A, 8'h00, 8'hFF};
    pq_gate_en_i = 1; pq_ok_i = 0;
    send_frame(pl, 1, 0, 0);
    check_bytes("R4 gated without quality", '{});
    pq_ok_i = 1;
    send_frame(pl, 1, 0, 0);
    check_bytes("R4 gated with quality", pl);
    pq_gate_en_i = 0; pq_ok_i = 0;
    send_frame(pl, 1, 0, 0);
    check_bytes("R4 gate off ignores quality", pl);
  endtask

  task automatic t_address();
    addr_chk_en_i = 1;
    send_frame('{8'h5B, 8'h22, 8'h33}, 1, 0, 0);
    check_bytes("R8 address mismatch dropped", '{});
    send_frame('{8'h5A, 8'h22, 8'h33}, 1, 0, 0);
    check_bytes("R8 address match kept", '{8'h5A, 8'h22, 8'h33});
    addr_chk_en_i = 0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_white_crc_status();
    t_threshold();
    t_double();
    t_pq_gate();
    t_address();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule